// File: doc/BRIEF.md
# Ownership-Based Snoopy Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snoop bus. Every line carries one of three states: invalid, read-only shared, or read-write owner. The processor side presents read and write requests and sees hit or completion through a ready signal. On the bus side the controller asks for the bus, issues its own read-miss, invalidate and write-back transactions once granted, and watches the transactions of the other controllers.

Ownership moves to whichever cache writes a line. A write to a shared line, or to an absent one, first broadcasts an invalidate. The cache then holds the only valid copy, and further writes touch nothing outside it. When a peer misses on a line this cache owns, the controller supplies the data. In that same cycle it refreshes main memory and drops to read-only, so both caches end up sharing a copy that memory also holds. Replacing an owned line writes it back first.

A cache line holds a single data word. The address splits into a low index field of log2(LINES) bits and a tag made of the remaining high bits. Bus command codes are 0 none, 1 read-miss, 2 invalidate and 3 write-back.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line is invalid. A read of any address then raises bus_req without cpu_ready, and a snooped read-miss draws no data supply.
- R2: A read whose line is shared or owned, with a matching tag, completes in the same cycle with cpu_ready and cpu_hit high, the stored word on cpu_rdata and bus_req low.
- R3: A read miss with no owner responding completes in its granted cycle. In that cycle bus_cmd is 1 and bus_addr is the request address, and the word comes from mem_rdata. The line is installed read-only.
- R4: During a read miss, a high rsp_owner makes the line take rsp_data instead of mem_rdata.
- R5: A write to an owned line completes in the same cycle with cpu_hit high, and neither bus_req nor mem_we is raised. A later read returns the new word.
- R6: A write to a shared line, or a write miss, completes in its granted cycle with bus_cmd 2 and leaves the line owned. A following write to it is a local hit.
- R7: A snooped invalidate (snp_cmd 2) whose address matches a valid line by tag makes that line invalid. An invalidate with the same index but another tag has no effect.
- R8: A snooped read-miss (snp_cmd 1) on an owned line raises snp_supply with the line's word on snp_data. In the same cycle mem_we is raised with that address and word, and the line becomes read-only. A snooped read-miss on a shared line, or on a tag mismatch, supplies nothing.
- R9: A miss whose line slot holds an owned line of another tag first spends one granted cycle on bus_cmd 3. In that cycle mem_we writes the old address and word and cpu_ready stays low; the fill follows. A shared victim is dropped with no write-back.
- R10: While snp_valid is high, cpu_ready stays low and bus_cmd is 0. bus_cmd is nonzero only while bus_req and bus_gnt are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion without bus traffic |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready on reads |
| bus_req | output | 1 | Snoop bus wanted |
| bus_gnt | input | 1 | Snoop bus granted to this controller |
| bus_cmd | output | 2 | Own transaction issued this cycle |
| bus_addr | output | ADDR_W | Address of own transaction |
| rsp_owner | input | 1 | A peer owner supplies the missed line |
| rsp_data | input | DATA_W | Word supplied by the peer owner |
| snp_valid | input | 1 | Peer transaction on the bus |
| snp_cmd | input | 2 | Peer transaction command |
| snp_addr | input | ADDR_W | Peer transaction address |
| snp_supply | output | 1 | This cache supplies the peer's miss |
| snp_data | output | DATA_W | Supplied word |
| mem_we | output | 1 | Main memory write strobe |
| mem_addr | output | ADDR_W | Main memory write address |
| mem_wdata | output | DATA_W | Main memory write word |
| mem_rdata | input | DATA_W | Main memory read word for fills |

## Verification
Two things can land in one cycle: a peer's transaction arriving on the snoop side, and this cache's pending processor request being ready to complete or issue. The bench provokes this in two ways. It holds a read request for a resident line while an unrelated invalidate is snooped. It also holds a granted read miss while a peer read-miss hits a line this cache owns. It judges the cycle by three things: the snooped action alone takes effect (supply and memory refresh), the processor side shows no ready and no command, and the deferred request finishes correctly in the next quiet cycle.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
   typedef enum logic [1:0] {
      ST_INV = 2'd0,
      ST_RO  = 2'd1,
      ST_RW  = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_RDMISS = 2'd1,
      CMD_INVAL  = 2'd2,
      CMD_WBACK  = 2'd3
   } bus_cmd_t;
endpackage

// File: rtl/coh_line_store.sv
`timescale 1ns/1ps
module coh_line_store
   import coh_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  a_idx,
   output line_st_t          a_st,
   output logic [TAG_W-1:0]  a_tag,
   output logic [DATA_W-1:0] a_data,
   input  logic [IDX_W-1:0]  b_idx,
   output line_st_t          b_st,
   output logic [TAG_W-1:0]  b_tag,
   output logic [DATA_W-1:0] b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_full,
   input  line_st_t          wr_st,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   line_st_t          st_v   [LINES];
   logic [TAG_W-1:0]  tag_v  [LINES];
   logic [DATA_W-1:0] data_v [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] data_r;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_r <= ST_INV;
         else if (sel) st_r <= wr_st;
      end

      always_ff @(posedge clk) begin
         if (sel && wr_full) begin
            tag_r  <= wr_tag;
            data_r <= wr_data;
         end
      end

      assign st_v[i]   = st_r;
      assign tag_v[i]  = tag_r;
      assign data_v[i] = data_r;
   end

   assign a_st   = st_v[a_idx];
   assign a_tag  = tag_v[a_idx];
   assign a_data = data_v[a_idx];
   assign b_st   = st_v[b_idx];
   assign b_tag  = tag_v[b_idx];
   assign b_data = data_v[b_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
`timescale 1ns/1ps
module coh_snoop_unit
   import coh_pkg::*;
#(
   parameter int TAG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              snp_valid,
   input  bus_cmd_t          snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  line_st_t          ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              upd_en,
   output line_st_t          upd_st,
   output logic              supply,
   output logic [DATA_W-1:0] supply_data
);
   logic match;

   always_comb begin
      match       = (ln_st != ST_INV) && (ln_tag == snp_tag);
      upd_en      = 1'b0;
      upd_st      = ST_INV;
      supply      = 1'b0;
      supply_data = '0;
      if (snp_valid && match) begin
         unique case (snp_cmd)
            CMD_RDMISS: if (ln_st == ST_RW) begin
               supply      = 1'b1;
               supply_data = ln_data;
               upd_en      = 1'b1;
               upd_st      = ST_RO;
            end
            CMD_INVAL: begin
               upd_en = 1'b1;
               upd_st = ST_INV;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/coh_cpu_side.sv
`timescale 1ns/1ps
module coh_cpu_side
   import coh_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  line_st_t          ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   input  logic              snp_busy,
   input  logic              bus_gnt,
   input  logic              rsp_owner,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output bus_cmd_t          bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              upd_en,
   output logic              upd_full,
   output line_st_t          upd_st,
   output logic [TAG_W-1:0]  upd_tag,
   output logic [DATA_W-1:0] upd_data,
   output logic              wb_we,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [DATA_W-1:0] wb_data
);
   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic              tag_eq, local_ok, victim_dirty, go;
   logic [DATA_W-1:0] fill;

   assign idx = cpu_addr[IDX_W-1:0];
   assign tag = cpu_addr[ADDR_W-1:IDX_W];

   always_comb begin
      tag_eq       = (ln_tag == tag);
      local_ok     = (ln_st != ST_INV) && tag_eq && (!cpu_we || ln_st == ST_RW);
      victim_dirty = (ln_st == ST_RW) && !tag_eq;
      go           = cpu_req && !snp_busy;
      fill         = rsp_owner ? rsp_data : mem_rdata;
      bus_req      = cpu_req && !local_ok;
      bus_addr     = victim_dirty ? {ln_tag, idx} : cpu_addr;
      cpu_ready    = 1'b0;
      cpu_hit      = 1'b0;
      cpu_rdata    = '0;
      bus_cmd      = CMD_NONE;
      upd_en       = 1'b0;
      upd_full     = 1'b0;
      upd_st       = ST_INV;
      upd_tag      = tag;
      upd_data     = cpu_wdata;
      wb_we        = 1'b0;
      wb_addr      = {ln_tag, idx};
      wb_data      = ln_data;
      if (go && local_ok) begin
         cpu_ready = 1'b1;
         cpu_hit   = 1'b1;
         if (cpu_we) begin
            upd_en   = 1'b1;
            upd_full = 1'b1;
            upd_st   = ST_RW;
         end else begin
            cpu_rdata = ln_data;
         end
      end else if (go && bus_gnt) begin
         if (victim_dirty) begin
            bus_cmd = CMD_WBACK;
            wb_we   = 1'b1;
            upd_en  = 1'b1;
            upd_st  = ST_INV;
         end else if (cpu_we) begin
            bus_cmd   = CMD_INVAL;
            cpu_ready = 1'b1;
            upd_en    = 1'b1;
            upd_full  = 1'b1;
            upd_st    = ST_RW;
         end else begin
            bus_cmd   = CMD_RDMISS;
            cpu_ready = 1'b1;
            cpu_rdata = fill;
            upd_en    = 1'b1;
            upd_full  = 1'b1;
            upd_st    = ST_RO;
            upd_data  = fill;
         end
      end
   end
endmodule

// File: rtl/coh_ctrl.sv
`timescale 1ns/1ps
module coh_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              rsp_owner,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("coh_ctrl: LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("coh_ctrl: ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("coh_ctrl: DATA_W must be positive");
   end

   line_st_t          a_st, b_st, s_st, c_st, wr_st;
   logic [TAG_W-1:0]  a_tag, b_tag, c_tag, wr_tag;
   logic [DATA_W-1:0] a_data, b_data, c_data, wb_data;
   logic              s_upd, c_upd, c_full, wb_we;
   logic              wr_en, wr_full;
   logic [IDX_W-1:0]  wr_idx;
   logic [ADDR_W-1:0] wb_addr;
   bus_cmd_t          cmd_e;

   coh_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(cpu_addr[IDX_W-1:0]), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
      .b_idx(snp_addr[IDX_W-1:0]), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_full(wr_full), .wr_st(wr_st),
      .wr_tag(wr_tag), .wr_data(c_data)
   );

   coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)),
      .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
      .ln_st(b_st), .ln_tag(b_tag), .ln_data(b_data),
      .upd_en(s_upd), .upd_st(s_st), .supply(snp_supply), .supply_data(snp_data)
   );

   coh_cpu_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu (
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .ln_st(a_st), .ln_tag(a_tag), .ln_data(a_data),
      .snp_busy(snp_valid), .bus_gnt(bus_gnt),
      .rsp_owner(rsp_owner), .rsp_data(rsp_data), .mem_rdata(mem_rdata),
      .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_cmd(cmd_e), .bus_addr(bus_addr),
      .upd_en(c_upd), .upd_full(c_full), .upd_st(c_st), .upd_tag(c_tag), .upd_data(c_data),
      .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
   );

   assign bus_cmd = cmd_e;

   always_comb begin
      wr_en   = s_upd | c_upd;
      wr_idx  = s_upd ? snp_addr[IDX_W-1:0] : cpu_addr[IDX_W-1:0];
      wr_st   = s_upd ? s_st : c_st;
      wr_full = !s_upd && c_full;
      wr_tag  = c_tag;
   end

   always_comb begin
      mem_we    = snp_supply | wb_we;
      mem_addr  = snp_supply ? snp_addr : wb_addr;
      mem_wdata = snp_supply ? snp_data : wb_data;
   end
endmodule

// File: rtl/coh_ctrl_checker.sv
`timescale 1ns/1ps
module coh_ctrl_checker #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_we,
   input logic              cpu_ready,
   input logic              cpu_hit,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              snp_valid,
   input logic [1:0]        snp_cmd,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              snp_supply,
   input logic [DATA_W-1:0] snp_data,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata
);
   assert_quiet_during_snoop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> (!cpu_ready && bus_cmd == 2'd0));

   assert_cmd_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != 2'd0) |-> (bus_gnt && bus_req));

   assert_supply_refreshes_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (mem_we && mem_addr == snp_addr && mem_wdata == snp_data));

   assert_supply_drops_ownership_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == 2'd1 && $past(snp_supply) && snp_addr == $past(snp_addr))
      |-> !snp_supply);

   assert_hit_is_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> (cpu_ready && !bus_req && bus_cmd == 2'd0));

   assert_wback_writes_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'd3) |-> (mem_we && mem_addr == bus_addr && !cpu_ready));

   assert_fill_completes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'd1) |-> (cpu_ready && !cpu_hit));

   assert_inval_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'd2) |-> (cpu_ready && cpu_we));

   assert_mem_write_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (snp_supply || bus_cmd == 2'd3));
endmodule

bind coh_ctrl coh_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
   .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
   .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
   .snp_supply(snp_supply), .snp_data(snp_data),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_coh_ctrl.sv
`timescale 1ns/1ps
module tb_coh_ctrl;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NV = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready, cpu_hit;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic          rsp_owner = 1'b0;
   logic [DW-1:0] rsp_data = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_supply;
   logic [DW-1:0] snp_data;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(8)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .rsp_owner(rsp_owner), .rsp_data(rsp_data),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_supply(snp_supply), .snp_data(snp_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // vector: we, addr, wdata, owner, fill, exp_hit, exp_first_cmd, exp_rdata
   localparam logic [60:0] VEC [NV] = '{
      {1'b0, 8'h10, 16'h0000, 1'b0, 16'h1111, 1'b0, 2'd1, 16'h1111}, // R3 read miss, memory
      {1'b0, 8'h10, 16'h0000, 1'b0, 16'h0000, 1'b1, 2'd0, 16'h1111}, // R2 read hit shared
      {1'b1, 8'h10, 16'hAAAA, 1'b0, 16'h0000, 1'b0, 2'd2, 16'h0000}, // R6 write shared
      {1'b1, 8'h10, 16'hBBBB, 1'b0, 16'h0000, 1'b1, 2'd0, 16'h0000}, // R5 write owned
      {1'b0, 8'h10, 16'h0000, 1'b0, 16'h0000, 1'b1, 2'd0, 16'hBBBB}, // R5 read back
      {1'b0, 8'h21, 16'h0000, 1'b1, 16'h2222, 1'b0, 2'd1, 16'h2222}, // R4 owner supplies
      {1'b1, 8'h32, 16'h3333, 1'b0, 16'h0000, 1'b0, 2'd2, 16'h0000}, // R6 write miss
      {1'b0, 8'h32, 16'h0000, 1'b0, 16'h0000, 1'b1, 2'd0, 16'h3333}, // R2 read hit owned
      {1'b0, 8'h18, 16'h0000, 1'b0, 16'h4444, 1'b0, 2'd3, 16'h4444}, // R9 owned victim
      {1'b0, 8'h10, 16'h0000, 1'b0, 16'h5555, 1'b0, 2'd1, 16'h5555}  // R9 shared victim
   };

   logic          r_hit, r_done, r_wb_seen;
   logic [1:0]    r_cmd;
   logic [DW-1:0] r_rdata, r_wb_data;
   logic [AW-1:0] r_wb_addr;
   logic          s_supply, s_mwe, s_ready;
   logic [DW-1:0] s_data, s_mwdata;
   logic [AW-1:0] s_maddr;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic own, input logic [DW-1:0] fill);
      bit first = 1'b0;
      r_hit = 1'b0; r_done = 1'b0; r_cmd = 2'd0; r_rdata = '0;
      r_wb_seen = 1'b0; r_wb_addr = '0; r_wb_data = '0;
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      rsp_owner = own; rsp_data = own ? fill : ~fill; mem_rdata = own ? ~fill : fill;
      bus_gnt = 1'b0;
      #1;
      if (cpu_ready) begin
         r_hit = cpu_hit; r_rdata = cpu_rdata; r_done = 1'b1;
      end else begin
         bus_gnt = 1'b1;
         #1;
         for (int k = 0; k < 4 && !r_done; k++) begin
            if (!first && bus_cmd != 2'd0) begin r_cmd = bus_cmd; first = 1'b1; end
            if (bus_cmd == 2'd3) begin
               r_wb_seen = 1'b1; r_wb_addr = mem_addr; r_wb_data = mem_wdata;
            end
            if (cpu_ready) begin
               r_rdata = cpu_rdata; r_done = 1'b1;
            end else begin
               @(posedge clk); #3;
            end
         end
      end
      @(posedge clk); #1;
      cpu_req = 1'b0; bus_gnt = 1'b0; rsp_owner = 1'b0;
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a);
      @(posedge clk); #1;
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
      #2;
      s_supply = snp_supply; s_data = snp_data; s_mwe = mem_we;
      s_maddr = mem_addr; s_mwdata = mem_wdata; s_ready = cpu_ready;
      @(posedge clk); #1;
      snp_valid = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         n_errs++;
         $display("FAIL watchdog expired, run hung");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1: reset state at the ports
      chk("R1 bus_cmd idle", 32'(bus_cmd), 0);
      chk("R1 mem_we idle", 32'(mem_we), 0);
      chk("R1 supply idle", 32'(snp_supply), 0);
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_addr = 8'h00;
      #1;
      chk("R1 first read misses ready", 32'(cpu_ready), 0);
      chk("R1 first read misses bus_req", 32'(bus_req), 1);
      @(posedge clk); #1 cpu_req = 1'b0;
      snoop(2'd1, 8'h00);
      chk("R1 no supply after reset", 32'(s_supply), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [60:0] v;
         v = VEC[i];
         access(v[60], v[59:52], v[51:36], v[35], v[34:19]);
         chk($sformatf("R2-R9 vec%0d completes", i), 32'(r_done), 1);
         chk($sformatf("R2-R9 vec%0d hit", i), 32'(r_hit), 32'(v[18]));
         chk($sformatf("R2-R9 vec%0d first cmd", i), 32'(r_cmd), 32'(v[17:16]));
         if (!v[60]) chk($sformatf("R2-R9 vec%0d rdata", i), 32'(r_rdata), 32'(v[15:0]));
      end

      // R9: write-back of owned line 0x32 when 0x3A replaces it
      access(1'b0, 8'h3A, 16'h0, 1'b0, 16'h6666);
      chk("R9 wb seen", 32'(r_wb_seen), 1);
      chk("R9 wb addr", 32'(r_wb_addr), 32'h32);
      chk("R9 wb data", 32'(r_wb_data), 32'h3333);
      chk("R9 fill data", 32'(r_rdata), 32'h6666);

      // R8: owner supplies a peer miss and refreshes memory
      access(1'b1, 8'h21, 16'h7777, 1'b0, 16'h0);
      chk("R6 write shared 0x21 inval", 32'(r_cmd), 2);
      snoop(2'd1, 8'h21);
      chk("R8 supply", 32'(s_supply), 1);
      chk("R8 supply data", 32'(s_data), 32'h7777);
      chk("R8 mem_we", 32'(s_mwe), 1);
      chk("R8 mem addr", 32'(s_maddr), 32'h21);
      chk("R8 mem data", 32'(s_mwdata), 32'h7777);
      snoop(2'd1, 8'h21);
      chk("R8 shared no resupply", 32'(s_supply), 0);
      access(1'b1, 8'h21, 16'h7878, 1'b0, 16'h0);
      chk("R8 line left shared", 32'(r_cmd), 2);
      snoop(2'd1, 8'h29);
      chk("R8 tag mismatch no supply", 32'(s_supply), 0);

      // R7: invalidate by tag
      snoop(2'd2, 8'h29);
      access(1'b0, 8'h21, 16'h0, 1'b0, 16'h0);
      chk("R7 other tag untouched hit", 32'(r_hit), 1);
      chk("R7 other tag untouched data", 32'(r_rdata), 32'h7878);
      snoop(2'd2, 8'h21);
      access(1'b0, 8'h21, 16'h0, 1'b0, 16'h8888);
      chk("R7 invalidated misses", 32'(r_cmd), 1);
      chk("R7 refill data", 32'(r_rdata), 32'h8888);

      // R10: hit request deferred by an unrelated snoop
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h3A; bus_gnt = 1'b1;
      snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 8'h05;
      #2;
      chk("R10 hit held during snoop", 32'(cpu_ready), 0);
      chk("R10 no cmd during snoop", 32'(bus_cmd), 0);
      @(posedge clk); #1;
      snp_valid = 1'b0;
      #1;
      chk("R10 hit after snoop", 32'(cpu_ready && cpu_hit), 1);
      chk("R10 hit data after snoop", 32'(cpu_rdata), 32'h6666);
      @(posedge clk); #1 cpu_req = 1'b0; bus_gnt = 1'b0;

      // R10: granted miss collides with a supply from an owned line
      access(1'b1, 8'h21, 16'h9999, 1'b0, 16'h0);
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h44; bus_gnt = 1'b1;
      mem_rdata = 16'h4040; rsp_owner = 1'b0;
      snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h21;
      #2;
      chk("R10 supply wins", 32'(snp_supply), 1);
      chk("R10 supply data", 32'(snp_data), 32'h9999);
      chk("R10 mem refresh addr", 32'(mem_addr), 32'h21);
      chk("R10 miss stalled ready", 32'(cpu_ready), 0);
      chk("R10 miss stalled cmd", 32'(bus_cmd), 0);
      @(posedge clk); #1;
      snp_valid = 1'b0;
      #1;
      chk("R10 miss issues after", 32'(bus_cmd), 1);
      chk("R10 miss data after", 32'(cpu_rdata), 32'h4040);
      @(posedge clk); #1 cpu_req = 1'b0; bus_gnt = 1'b0;

      // R1: reset in mid-run clears lines
      rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_addr = 8'h3A;
      #1;
      chk("R1 reset clears line", 32'(cpu_ready), 0);
      chk("R1 reset clears line bus_req", 32'(bus_req), 1);
      @(posedge clk); #1 cpu_req = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule